// File: doc/BRIEF.md
# Preemptive Fixed-Priority DMA Channel Arbiter

This block picks which of several DMA channels the transfer engine serves next. Each channel has its own priority register. The register holds a programmable rank, a read-only group rank, a bit that lets the channel be suspended, and a bit that stops the channel from suspending others. When nothing is being served, the highest-ranked pending request wins. The winner is presented as a registered channel index together with a valid flag.

While a channel is being served, a newly raised request may suspend it, but only when three conditions hold together. The requester must outrank the active channel strictly. The active channel must allow suspension. The requester must not be barred from suspending. Only one level of suspension exists. The preempting channel cannot itself be suspended. When it reports completion, the suspended channel is granted again ahead of anything else that is pending. Between any two services the valid flag drops for exactly one cycle.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset, grant_valid is 0. Every channel n reads back rank n, group rank GRP_PRI (0 by default), and both flag bits 0.
- R2: A register word has the rank in bits 3:0, the group rank in bits 5:4, the no-suspend-others bit in bit 6 and the may-be-suspended bit in bit 7. A write updates the rank and both flags of the addressed channel. Bits 5:4 always read GRP_PRI, whatever was written.
- R3: When nothing is being served and requests are pending, the clock edge that samples them raises grant_valid. grant_ch then names the request with the highest rank. Among equal ranks, the higher channel index wins.
- R4: A done pulse during a service drops grant_valid for exactly one cycle. After that cycle, arbitration resumes.
- R5: A pending request suspends the active channel when three conditions all hold: its rank is strictly higher, the active channel's may-be-suspended bit is 1, and the requester's no-suspend-others bit is 0. grant_valid then reads 0 for one cycle, and the following cycle grants the requester.
- R6: An active channel whose may-be-suspended bit is 0 is never suspended, whatever the rank of competing requests.
- R7: A requester whose no-suspend-others bit is 1 never suspends an active channel.
- R8: A requester whose rank equals the active channel's rank does not suspend it.
- R9: A channel that suspended another is not itself suspended. On its done pulse, the suspended channel is granted again after a one-cycle gap, ahead of any other pending request.
- R10: A done pulse while grant_valid is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | NCH | Per-channel service request |
| done | input | 1 | Engine pulse: the granted service has finished |
| grant_valid | output | 1 | A channel is currently granted |
| grant_ch | output | CH_W | Index of the granted channel |
| reg_wr | input | 1 | Write strobe for the priority registers |
| reg_addr | input | CH_W | Channel whose register is accessed |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data of the addressed register (combinational) |

## Verification
The bench raises two requests of equal rank at once. A design that resolves ties toward the lower index grants the wrong channel. It raises a higher-ranked request against an active channel three times, each time with exactly one of the three suspension conditions missing. A design that ignores the victim's permission, the requester's bar, or the strict comparison would suspend the active channel. In the nested case, a third, even higher request stays pending while a preemptor runs. When the preemptor finishes, a design that forgets the suspended channel, or lets new requests win over it, grants the wrong channel after the gap. A stray done pulse while idle, and a write of ones to the group field, check that neither one disturbs state.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
   // Register word: rank | group rank | no-suspend-others | may-be-suspended
   function automatic int reg_width(int pri_w, int grp_w);
      return pri_w + grp_w + 2;
   endfunction
endpackage

// File: rtl/dma_arb_prio_regs.sv
module dma_arb_prio_regs
   import dma_arb_pkg::*;
#(
   parameter int NCH   = 16,
   parameter int PRI_W = 4,
   parameter int GRP_W = 2,
   parameter logic [GRP_W-1:0] GRP_PRI = '0,
   localparam int CH_W  = $clog2(NCH),
   localparam int REG_W = reg_width(PRI_W, GRP_W)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       reg_wr,
   input  logic [CH_W-1:0]            reg_addr,
   input  logic [REG_W-1:0]           reg_wdata,
   output logic [REG_W-1:0]           reg_rdata,
   output logic [NCH-1:0][PRI_W-1:0]  pri_q,
   output logic [NCH-1:0]             pre_en_q,
   output logic [NCH-1:0]             no_pre_q
);
   localparam int DIS_BIT = PRI_W + GRP_W;
   localparam int EN_BIT  = PRI_W + GRP_W + 1;

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pri_q[g]    <= PRI_W'(g);
            pre_en_q[g] <= 1'b0;
            no_pre_q[g] <= 1'b0;
         end else if (reg_wr && (int'(reg_addr) == g)) begin
            pri_q[g]    <= reg_wdata[PRI_W-1:0];
            no_pre_q[g] <= reg_wdata[DIS_BIT];
            pre_en_q[g] <= reg_wdata[EN_BIT];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (int'(reg_addr) < NCH)
         reg_rdata = {pre_en_q[reg_addr], no_pre_q[reg_addr], GRP_PRI, pri_q[reg_addr]};
   end

   // R2: the group field never follows written data
   always_comb begin
      if (rst_n) assert_grp_ro_R2: assert (reg_rdata[DIS_BIT-1:PRI_W] == GRP_PRI || int'(reg_addr) >= NCH);
   end
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
   parameter int NCH      = 16,
   parameter int PRI_W    = 4,
   parameter bit TIE_HIGH = 1'b1,
   localparam int CH_W    = $clog2(NCH)
) (
   input  logic [NCH-1:0]             mask,
   input  logic [NCH-1:0][PRI_W-1:0]  pri,
   output logic                       found,
   output logic [CH_W-1:0]            idx,
   output logic [PRI_W-1:0]           best
);
   if (TIE_HIGH) begin : g_tie_high
      always_comb begin
         found = 1'b0;
         idx   = '0;
         best  = '0;
         for (int i = 0; i < NCH; i++) begin
            if (mask[i] && (!found || pri[i] >= best)) begin
               found = 1'b1;
               idx   = CH_W'(i);
               best  = pri[i];
            end
         end
      end
   end else begin : g_tie_low
      always_comb begin
         found = 1'b0;
         idx   = '0;
         best  = '0;
         for (int i = 0; i < NCH; i++) begin
            if (mask[i] && (!found || pri[i] > best)) begin
               found = 1'b1;
               idx   = CH_W'(i);
               best  = pri[i];
            end
         end
      end
   end
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
   import dma_arb_pkg::*;
#(
   parameter int NCH   = 16,
   parameter int PRI_W = 4,
   parameter int GRP_W = 2,
   parameter logic [GRP_W-1:0] GRP_PRI = '0,
   parameter bit TIE_HIGH = 1'b1,
   localparam int CH_W  = $clog2(NCH),
   localparam int REG_W = reg_width(PRI_W, GRP_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCH-1:0]   req,
   input  logic             done,
   output logic             grant_valid,
   output logic [CH_W-1:0]  grant_ch,
   input  logic             reg_wr,
   input  logic [CH_W-1:0]  reg_addr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata
);
   if (NCH < 2)   begin : g_bad_nch $error("NCH must be at least 2");   end
   if (PRI_W < 1) begin : g_bad_pri $error("PRI_W must be at least 1"); end
   if (GRP_W < 1) begin : g_bad_grp $error("GRP_W must be at least 1"); end

   logic [NCH-1:0][PRI_W-1:0] pri_q;
   logic [NCH-1:0]            pre_en_q, no_pre_q;

   dma_arb_prio_regs #(.NCH(NCH), .PRI_W(PRI_W), .GRP_W(GRP_W), .GRP_PRI(GRP_PRI)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pri_q(pri_q), .pre_en_q(pre_en_q), .no_pre_q(no_pre_q)
   );

   // service state
   logic            act_valid, hold, susp_valid;
   logic [CH_W-1:0] act_ch, susp_ch;

   // idle choice
   logic            idle_found;
   logic [CH_W-1:0] idle_idx;
   logic [PRI_W-1:0] idle_pri;

   dma_arb_pick #(.NCH(NCH), .PRI_W(PRI_W), .TIE_HIGH(TIE_HIGH)) u_idle_pick (
      .mask(req), .pri(pri_q), .found(idle_found), .idx(idle_idx), .best(idle_pri)
   );

   // preemption candidate: requesters allowed to suspend, excluding the active one
   logic [NCH-1:0]  act_oh, pre_mask;
   logic            pre_found, pre_go;
   logic [CH_W-1:0] pre_idx;
   logic [PRI_W-1:0] pre_pri;

   always_comb begin
      act_oh = '0;
      act_oh[act_ch] = 1'b1;
      pre_mask = req & ~no_pre_q & ~act_oh;
   end

   dma_arb_pick #(.NCH(NCH), .PRI_W(PRI_W), .TIE_HIGH(TIE_HIGH)) u_pre_pick (
      .mask(pre_mask), .pri(pri_q), .found(pre_found), .idx(pre_idx), .best(pre_pri)
   );

   assign pre_go = act_valid && !susp_valid && pre_en_q[act_ch] &&
                   pre_found && (pre_pri > pri_q[act_ch]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_valid  <= 1'b0;
         hold       <= 1'b0;
         act_ch     <= '0;
         susp_valid <= 1'b0;
         susp_ch    <= '0;
      end else if (!act_valid) begin
         if (hold) begin
            act_valid <= 1'b1;
            hold      <= 1'b0;
         end else if (idle_found) begin
            act_valid <= 1'b1;
            act_ch    <= idle_idx;
         end
      end else if (done) begin
         act_valid <= 1'b0;
         if (susp_valid) begin
            act_ch     <= susp_ch;
            susp_valid <= 1'b0;
            hold       <= 1'b1;
         end
      end else if (pre_go) begin
         susp_valid <= 1'b1;
         susp_ch    <= act_ch;
         act_ch     <= pre_idx;
         act_valid  <= 1'b0;
         hold       <= 1'b1;
      end
   end

   assign grant_valid = act_valid;
   assign grant_ch    = act_ch;

   assert_gap_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      act_valid && done |=> !grant_valid);

   assert_victim_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(susp_valid) |-> $past(pre_en_q[act_ch]));

   assert_requester_allowed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(susp_valid) |-> !no_pre_q[act_ch]);

   assert_single_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
      susp_valid && !(act_valid && done) |=> susp_valid && $stable(susp_ch));

   assert_grant_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      act_valid && !done && !pre_go |=> grant_valid && $stable(grant_ch));

   assert_idle_done_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !act_valid && !hold && !idle_found |=> !grant_valid);
endmodule

// File: tb/dma_prio_arbiter_tb.sv
module dma_prio_arbiter_tb;
   localparam int NCH = 16;
   localparam int CH_W = 4;
   localparam int REG_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NCH-1:0] req = '0;
   logic done = 1'b0;
   logic grant_valid;
   logic [CH_W-1:0] grant_ch;
   logic reg_wr = 1'b0;
   logic [CH_W-1:0] reg_addr = '0;
   logic [REG_W-1:0] reg_wdata = '0;
   logic [REG_W-1:0] reg_rdata;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   dma_prio_arbiter u_dut (
      .clk(clk), .rst_n(rst_n), .req(req), .done(done),
      .grant_valid(grant_valid), .grant_ch(grant_ch),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic do_reset();
      req = '0; done = 1'b0; reg_wr = 1'b0;
      rst_n = 1'b0;
      step(); step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic wr(input int ch, input int val);
      reg_addr = CH_W'(ch); reg_wdata = REG_W'(val); reg_wr = 1'b1;
      step();
      reg_wr = 1'b0;
   endtask

   task automatic expect_grant(input string tag, input int ch);
      check(grant_valid === 1'b1, tag, int'(grant_valid), 1);
      check(grant_ch === CH_W'(ch), tag, int'(grant_ch), ch);
   endtask

   task automatic expect_idle(input string tag);
      check(grant_valid === 1'b0, tag, int'(grant_valid), 0);
   endtask

   // finish current service, dropping the given requests
   task automatic finish(input logic [NCH-1:0] drop);
      done = 1'b1; req = req & ~drop;
      step();
      done = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      expect_idle("R1 valid after reset");
      for (int n = 0; n < NCH; n++) begin
         reg_addr = CH_W'(n); #1;
         check(reg_rdata === REG_W'(n), "R1 reset register", int'(reg_rdata), n);
      end
   endtask

   task automatic t_regs();
      do_reset();
      wr(3, 8'hFF);
      reg_addr = 4'd3; #1;
      check(reg_rdata === 8'hCF, "R2 write with group bits", int'(reg_rdata), 'hCF);
      wr(3, 8'h35);
      reg_addr = 4'd3; #1;
      check(reg_rdata === 8'h05, "R2 rewrite", int'(reg_rdata), 'h05);
      reg_addr = 4'd4; #1;
      check(reg_rdata === 8'h04, "R2 neighbour untouched", int'(reg_rdata), 4);
   endtask

   task automatic t_idle_order();
      do_reset();
      wr(2, 9); wr(5, 9); wr(7, 3);
      req = (16'h1 << 2) | (16'h1 << 5) | (16'h1 << 7);
      step();
      expect_grant("R3 tie to higher index", 5);
      finish(16'h1 << 5);
      expect_idle("R4 gap after done");
      step();
      expect_grant("R3 next highest rank", 2);
      finish(16'h1 << 2);
      expect_idle("R4 gap after done 2");
      step();
      expect_grant("R3 lowest remaining", 7);
      finish(16'h1 << 7);
      step();
      expect_idle("R4 no request stays idle");
   endtask

   task automatic t_done_idle();
      do_reset();
      done = 1'b1; step(); done = 1'b0;
      expect_idle("R10 stray done while idle");
      step();
      expect_idle("R10 still idle");
      req = 16'h1 << 1;
      step();
      expect_grant("R10 normal grant after stray done", 1);
   endtask

   task automatic t_preempt();
      do_reset();
      wr(4, 8'h82);   // rank 2, may be suspended
      wr(9, 8'h8A);   // rank 10, may be suspended
      wr(12, 8'h0F);  // rank 15
      req = 16'h1 << 4;
      step();
      expect_grant("R5 victim granted", 4);
      req |= 16'h1 << 9;
      step();
      expect_idle("R5 gap on preemption");
      step();
      expect_grant("R5 preemptor granted", 9);
      req |= 16'h1 << 12;
      step(); step();
      expect_grant("R9 preemptor not suspended", 9);
      finish(16'h1 << 9);
      expect_idle("R9 gap before resume");
      step();
      expect_grant("R9 suspended channel resumed first", 4);
      finish(16'h1 << 4);
      step();
      expect_grant("R9 pending request afterwards", 12);
   endtask

   task automatic t_no_enable();
      do_reset();
      wr(4, 8'h02);   // rank 2, not suspendable
      wr(9, 8'h0A);
      req = 16'h1 << 4;
      step();
      req |= 16'h1 << 9;
      step(); step();
      expect_grant("R6 victim without permission kept", 4);
   endtask

   task automatic t_barred();
      do_reset();
      wr(4, 8'h82);
      wr(9, 8'h4A);   // rank 10, barred from suspending
      req = 16'h1 << 4;
      step();
      req |= 16'h1 << 9;
      step(); step();
      expect_grant("R7 barred requester cannot suspend", 4);
   endtask

   task automatic t_equal();
      do_reset();
      wr(4, 8'h85);
      wr(9, 8'h05);
      req = 16'h1 << 4;
      step();
      req |= 16'h1 << 9;
      step(); step();
      expect_grant("R8 equal rank no suspension", 4);
      finish(16'h1 << 4);
      step();
      expect_grant("R8 equal rank served after", 9);
   endtask

   initial begin
      t_reset();
      t_regs();
      t_idle_order();
      t_done_idle();
      t_preempt();
      t_no_enable();
      t_barred();
      t_equal();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule